// File: doc/BRIEF.md
# Buffered Synchronous Serial Transceiver

This block is an 8-bit full-duplex synchronous serial port. On every serial-clock period it sends one bit out and takes one bit in. A one-byte transmit holding register sits in front of the transmit shifter and a one-byte receive holding register sits behind the receive shifter. Software can therefore load the next byte while the current one is still moving, and bytes go out back to back.

The processor side uses strobes and level inputs:
- a control write that latches the operating mode, the clock source, the bit order and a run bit;
- a transmit write;
- a receive-read strobe;
- an error-clear strobe;
- status outputs and a one-cycle interrupt request for each byte received.

On the serial side the clock is either generated by a programmable divider, which drives the clock pin and idles high, or taken from the pin through a synchroniser. Data out changes on falling clock edges and data in is sampled on rising edges. Because data in goes through its own two-flop synchroniser, the internal half period must be at least three system clocks (`sck_div` of 2 or more).

Top module: `sio_xcvr`

## Requirements
- R1: After reset the outputs are: transmit-empty 1; busy, shifting, receive-full, receive-error and irq 0; `sck_o` 1; `sdo` 1.
- R2: Shifting starts only when the latched mode equals 2'b10 and the run bit is 1. With any other mode value the run bit is ignored: the clock stays high and busy stays 0.
- R3: A transmit write sets transmit-empty to 0 on the next cycle, and this takes priority over any event that would set it in that cycle.
- R4: Busy and shifting both rise in the cycle of the falling edge that loads a byte. Shifting falls when the eighth rising edge completes the byte. Busy also falls then, but only if the run bit is 0 at that moment.
- R5: Bit order: with the order bit 0 the MSB goes first on `sdo` and the first sampled bit lands in the MSB; with the order bit 1 both directions are LSB first.
- R6: Transmit-empty returns to 1 on the first rising edge after a load. If the next byte is written before the current byte ends, it starts on the very next falling edge, so consecutive bytes are exactly 16 half periods apart.
- R7: At byte completion, with no error and receive-full 0, the received byte enters the receive register, receive-full sets and irq is high for exactly one cycle. A read strobe clears receive-full on the next cycle.
- R8: A byte that completes while receive-full is 1 sets receive-error. The receive register keeps its old value and no irq is raised.
- R9: While receive-error is 1, completing bytes change neither the receive register nor receive-full, and raise no irq. Receive-error stays set until the clear strobe, which clears it on the next cycle.
- R10: With the internal clock, `sck_oe` is 1, `sck_o` is high whenever no byte is shifting, and each clock phase lasts `sck_div`+1 system clocks.
- R11: With the external clock, `sck_oe` is 0 and `sck_i` passes through a two-flop synchroniser. The first synchronised falling edge after a ready start loads the byte, and received data reaches the receive register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Latch the four control fields |
| ctrl_mode | input | 2 | Operating mode; 2'b10 is transmit/receive |
| ctrl_ext_clk | input | 1 | 1 = clock from pin, 0 = internal divider |
| ctrl_lsb_first | input | 1 | 1 = LSB first, 0 = MSB first |
| ctrl_start | input | 1 | Run bit |
| sck_div | input | DIV_W | Internal clock half period minus one, in system clocks |
| tx_we | input | 1 | Write strobe for the transmit register |
| tx_data | input | DATA_W | Transmit byte |
| rx_rd | input | 1 | Read strobe, clears receive-full |
| rx_data | output | DATA_W | Receive register |
| err_clr | input | 1 | Clears receive-error |
| st_busy | output | 1 | Transfer session active |
| st_shifting | output | 1 | Byte in the shifters |
| st_tx_empty | output | 1 | Transmit register free |
| st_rx_full | output | 1 | Receive register holds unread data |
| st_rx_err | output | 1 | Receive overrun, sticky |
| irq | output | 1 | One-cycle receive interrupt request |
| sck_i | input | 1 | Serial clock from pin |
| sck_o | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Drive enable for the clock pin |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
With the internal clock and `sck_div`=3, each clock phase lasts four cycles. `sdo` moves in the cycle of each falling edge and is sampled a full phase later, on the rising edge. The completed byte, receive-full and irq all appear in the cycle of the eighth rising edge. Strobe-driven flags (transmit-empty, receive-full, receive-error) change one cycle after their strobe. The bench checks them on the falling system-clock edge after that, while the scoreboard monitor compares serial bytes and irq data on the falling system-clock edge of the cycle they appear. The spacing between back-to-back bytes is checked against 64 cycles. Under the external clock every event lags the pin by the three synchroniser stages, so the bench holds each pin phase for eight cycles and waits for the scoreboard rather than for a fixed count.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_RSV1 = 2'b01,
    MODE_TRX  = 2'b10,
    MODE_RSV3 = 2'b11
  } sio_mode_e;

  typedef struct packed {
    logic fall;
    logic rise;
  } sck_evt_t;
endpackage

// File: rtl/sio_sck_gen.sv
module sio_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_sel,
  input  logic                run,
  input  logic [DIV_W-1:0]    half_div,
  input  logic                sck_pin,
  output logic                sck_int,
  output sio_pkg::sck_evt_t   evt
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic [2:0]       sync_q, sync_d;
  logic             tick;

  always_comb begin
    tick   = run && !ext_sel && (cnt_q == half_div);
    cnt_d  = cnt_q;
    sck_d  = sck_q;
    sync_d = {sync_q[1:0], sck_pin};
    if (ext_sel) begin
      cnt_d = '0;
      sck_d = 1'b1;
    end else if (tick) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else if (run) begin
      cnt_d = cnt_q + DIV_W'(1);
    end else begin
      cnt_d = '0;
    end
    evt.fall = ext_sel ? (sync_q[2] & ~sync_q[1]) : (tick & sck_q);
    evt.rise = ext_sel ? (~sync_q[2] & sync_q[1]) : (tick & ~sck_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sck_q  <= 1'b1;
      sync_q <= 3'b111;
    end else begin
      cnt_q  <= cnt_d;
      sck_q  <= sck_d;
      sync_q <= sync_d;
    end
  end

  assign sck_int = sck_q;
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sio_pkg::sck_evt_t evt,
  input  logic              lsb_first,
  input  logic              ready,
  input  logic [W-1:0]      load_word,
  input  logic              sdi_pin,
  output logic              sdo,
  output logic              active,
  output logic              load,
  output logic              done,
  output logic [W-1:0]      rx_word
);
  localparam int CW = $clog2(W + 1);
  localparam int RW = $clog2(W);

  logic [W-1:0]  tx_q, tx_d, rx_q, rx_d;
  logic [CW-1:0] fcnt_q, fcnt_d;
  logic [RW-1:0] rcnt_q, rcnt_d;
  logic          sdo_q, sdo_d;
  logic [1:0]    sdi_sync_q;

  always_comb begin
    active  = (fcnt_q != '0);
    load    = evt.fall && !active && ready;
    done    = evt.rise && active && (rcnt_q == RW'(W - 1));
    rx_word = lsb_first ? {sdi_sync_q[1], rx_q[W-1:1]} : {rx_q[W-2:0], sdi_sync_q[1]};
    tx_d    = tx_q;
    rx_d    = rx_q;
    fcnt_d  = fcnt_q;
    rcnt_d  = rcnt_q;
    sdo_d   = sdo_q;
    if (load) begin
      sdo_d  = lsb_first ? load_word[0] : load_word[W-1];
      tx_d   = lsb_first ? {1'b0, load_word[W-1:1]} : {load_word[W-2:0], 1'b0};
      fcnt_d = CW'(1);
    end else if (evt.fall && active && (fcnt_q != CW'(W))) begin
      sdo_d  = lsb_first ? tx_q[0] : tx_q[W-1];
      tx_d   = lsb_first ? {1'b0, tx_q[W-1:1]} : {tx_q[W-2:0], 1'b0};
      fcnt_d = fcnt_q + CW'(1);
    end
    if (evt.rise && active) begin
      rx_d = rx_word;
      if (done) begin
        rcnt_d = '0;
        fcnt_d = '0;
      end else begin
        rcnt_d = rcnt_q + RW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q       <= '0;
      rx_q       <= '0;
      fcnt_q     <= '0;
      rcnt_q     <= '0;
      sdo_q      <= 1'b1;
      sdi_sync_q <= 2'b00;
    end else begin
      tx_q       <= tx_d;
      rx_q       <= rx_d;
      fcnt_q     <= fcnt_d;
      rcnt_q     <= rcnt_d;
      sdo_q      <= sdo_d;
      sdi_sync_q <= {sdi_sync_q[0], sdi_pin};
    end
  end

  assign sdo = sdo_q;
endmodule

// File: rtl/sio_xcvr.sv
module sio_xcvr #(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [1:0]        ctrl_mode,
  input  logic              ctrl_ext_clk,
  input  logic              ctrl_lsb_first,
  input  logic              ctrl_start,
  input  logic [DIV_W-1:0]  sck_div,
  input  logic              tx_we,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  input  logic              err_clr,
  output logic              st_busy,
  output logic              st_shifting,
  output logic              st_tx_empty,
  output logic              st_rx_full,
  output logic              st_rx_err,
  output logic              irq,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              sdo,
  input  logic              sdi
);
  import sio_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  sio_mode_e         mode_q, mode_d;
  logic              ext_q, ext_d, lsb_q, lsb_d, start_q, start_d;
  logic [DATA_W-1:0] txbuf_q, txbuf_d, rxbuf_q, rxbuf_d, rx_word;
  logic              tx_empty_q, tx_empty_d, load_pend_q, load_pend_d;
  logic              rx_full_q, rx_full_d, rx_err_q, rx_err_d;
  logic              busy_q, busy_d, irq_q, irq_d;
  logic              ready, run, active, load, done, sck_int;
  sck_evt_t          evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign ready = start_q && (mode_q == MODE_TRX) && !tx_empty_q;
  assign run   = active || ready;

  sio_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk(clk), .rst_n(rst_int_n), .ext_sel(ext_q), .run(run),
    .half_div(sck_div), .sck_pin(sck_i), .sck_int(sck_int), .evt(evt)
  );

  sio_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .evt(evt), .lsb_first(lsb_q), .ready(ready),
    .load_word(txbuf_q), .sdi_pin(sdi), .sdo(sdo), .active(active),
    .load(load), .done(done), .rx_word(rx_word)
  );

  always_comb begin
    mode_d      = mode_q;
    ext_d       = ext_q;
    lsb_d       = lsb_q;
    start_d     = start_q;
    txbuf_d     = txbuf_q;
    tx_empty_d  = tx_empty_q;
    load_pend_d = load_pend_q;
    rxbuf_d     = rxbuf_q;
    rx_full_d   = rx_full_q;
    rx_err_d    = rx_err_q;
    busy_d      = busy_q;
    irq_d       = 1'b0;
    if (ctrl_we) begin
      mode_d  = sio_mode_e'(ctrl_mode);
      ext_d   = ctrl_ext_clk;
      lsb_d   = ctrl_lsb_first;
      start_d = ctrl_start;
    end
    if (load) begin
      load_pend_d = 1'b1;
      busy_d      = 1'b1;
    end
    if (evt.rise && load_pend_q) begin
      load_pend_d = 1'b0;
      tx_empty_d  = 1'b1;
    end
    if (tx_we) begin
      txbuf_d     = tx_data;
      tx_empty_d  = 1'b0;
      load_pend_d = 1'b0;
    end
    if (rx_rd)   rx_full_d = 1'b0;
    if (err_clr) rx_err_d  = 1'b0;
    if (done) begin
      if (!start_q) busy_d = 1'b0;
      if (!rx_err_q) begin
        if (rx_full_q) begin
          rx_err_d = 1'b1;
        end else begin
          rxbuf_d   = rx_word;
          rx_full_d = 1'b1;
          irq_d     = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q      <= MODE_OFF;
      ext_q       <= 1'b0;
      lsb_q       <= 1'b0;
      start_q     <= 1'b0;
      txbuf_q     <= '0;
      tx_empty_q  <= 1'b1;
      load_pend_q <= 1'b0;
      rxbuf_q     <= '0;
      rx_full_q   <= 1'b0;
      rx_err_q    <= 1'b0;
      busy_q      <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      ext_q       <= ext_d;
      lsb_q       <= lsb_d;
      start_q     <= start_d;
      txbuf_q     <= txbuf_d;
      tx_empty_q  <= tx_empty_d;
      load_pend_q <= load_pend_d;
      rxbuf_q     <= rxbuf_d;
      rx_full_q   <= rx_full_d;
      rx_err_q    <= rx_err_d;
      busy_q      <= busy_d;
      irq_q       <= irq_d;
    end
  end

  assign rx_data     = rxbuf_q;
  assign st_busy     = busy_q;
  assign st_shifting = active;
  assign st_tx_empty = tx_empty_q;
  assign st_rx_full  = rx_full_q;
  assign st_rx_err   = rx_err_q;
  assign irq         = irq_q;
  assign sck_o       = sck_int;
  assign sck_oe      = !ext_q;
endmodule

// File: rtl/sio_xcvr_chk.sv
module sio_xcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_we,
  input logic err_clr,
  input logic irq,
  input logic st_busy,
  input logic st_shifting,
  input logic st_tx_empty,
  input logic st_rx_full,
  input logic st_rx_err,
  input logic sck_o,
  input logic sck_oe
);
  p_txwr_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_we |=> !st_tx_empty);

  p_shift_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_shifting |-> st_busy);

  p_irq_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_with_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> st_rx_full);

  p_irq_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !st_rx_err);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rx_err && !err_clr) |=> st_rx_err);

  p_sck_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_oe && !st_shifting) |-> sck_o);
endmodule

bind sio_xcvr sio_xcvr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_we(tx_we), .err_clr(err_clr), .irq(irq),
  .st_busy(st_busy), .st_shifting(st_shifting), .st_tx_empty(st_tx_empty),
  .st_rx_full(st_rx_full), .st_rx_err(st_rx_err), .sck_o(sck_o), .sck_oe(sck_oe)
);

// File: tb/sio_xcvr_tb_top.sv
module sio_xcvr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 3;

  logic       clk = 1'b0;
  logic       rst_n, ctrl_we, ctrl_ext_clk, ctrl_lsb_first, ctrl_start;
  logic [1:0] ctrl_mode;
  logic [7:0] sck_div, tx_data, rx_data;
  logic       tx_we, rx_rd, err_clr, st_busy, st_shifting, st_tx_empty;
  logic       st_rx_full, st_rx_err, irq, sck_i, sck_o, sck_oe, sdo, sdi;

  int checks = 0, fails = 0, cyc = 0, tx_seen = 0, rx_seen = 0;
  int byte_t[16];
  bit cur_ext = 1'b0, cur_lsb = 1'b0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign sdi = ~sdo;

  sio_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_mode(ctrl_mode),
    .ctrl_ext_clk(ctrl_ext_clk), .ctrl_lsb_first(ctrl_lsb_first), .ctrl_start(ctrl_start),
    .sck_div(sck_div), .tx_we(tx_we), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
    .err_clr(err_clr), .st_busy(st_busy), .st_shifting(st_shifting),
    .st_tx_empty(st_tx_empty), .st_rx_full(st_rx_full), .st_rx_err(st_rx_err),
    .irq(irq), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sdo(sdo), .sdi(sdi)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic set_ctrl(input logic [1:0] m, input bit ext, input bit lsb, input bit st);
    @(negedge clk);
    ctrl_mode = m; ctrl_ext_clk = ext; ctrl_lsb_first = lsb; ctrl_start = st; ctrl_we = 1'b1;
    cur_ext = ext; cur_lsb = lsb;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  // driver: pushes the expected serial byte and, if a receive irq is due, its data
  task automatic send(input logic [7:0] b, input bit want_rx);
    tx_q.push_back(b);
    if (want_rx) rx_q.push_back(~b);
    @(negedge clk);
    tx_data = b; tx_we = 1'b1;
    @(negedge clk);
    tx_we = 1'b0;
    chk(st_tx_empty == 1'b0, "R3 tx write clears empty", int'(st_tx_empty), 0);
  endtask

  task automatic pulse_rd();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
    chk(st_rx_full == 1'b0, "R7 read clears full", int'(st_rx_full), 0);
  endtask

  task automatic wait_txe();
    while (!st_tx_empty) @(negedge clk);
  endtask

  task automatic wait_tx(input int n);
    while (tx_seen < n) @(negedge clk);
  endtask

  task automatic wait_rx(input int n);
    while (rx_seen < n) @(negedge clk);
  endtask

  // monitor: rebuilds serial bytes at rising clock-line edges, checks irq data
  bit prev_line = 1'b1;
  int nbits = 0;
  logic [7:0] shreg = '0;
  always @(negedge clk) begin
    logic line;
    logic [7:0] e;
    if (!rst_n) begin
      prev_line = 1'b1; nbits = 0;
    end else begin
      line = cur_ext ? sck_i : sck_o;
      if (line && !prev_line) begin
        if (cur_lsb) shreg[nbits] = sdo; else shreg[7-nbits] = sdo;
        nbits++;
        if (nbits == 8) begin
          nbits = 0;
          if (tx_q.size() == 0) chk(1'b0, "R5 unexpected serial byte", int'(shreg), 0);
          else begin
            e = tx_q.pop_front();
            chk(shreg == e, "R5 serial out order", int'(shreg), int'(e));
          end
          byte_t[tx_seen] = cyc;
          tx_seen++;
        end
      end
      prev_line = line;
      if (irq) begin
        if (rx_q.size() == 0) chk(1'b0, "R8 unexpected irq", int'(rx_data), 0);
        else begin
          e = rx_q.pop_front();
          chk(rx_data == e, "R7 received byte at irq", int'(rx_data), int'(e));
        end
        chk(st_rx_full == 1'b1, "R7 full with irq", int'(st_rx_full), 1);
        rx_seen++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    bit idle_ok;
    rst_n = 1'b0; ctrl_we = 1'b0; ctrl_mode = 2'b00; ctrl_ext_clk = 1'b0;
    ctrl_lsb_first = 1'b0; ctrl_start = 1'b0; sck_div = 8'(DIV); tx_we = 1'b0;
    tx_data = '0; rx_rd = 1'b0; err_clr = 1'b0; sck_i = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(st_tx_empty == 1'b1, "R1 reset tx empty", int'(st_tx_empty), 1);
    chk({st_busy, st_shifting, st_rx_full, st_rx_err, irq} == 5'b0, "R1 reset flags",
        int'({st_busy, st_shifting, st_rx_full, st_rx_err, irq}), 0);
    chk(sck_o == 1'b1 && sdo == 1'b1, "R1 reset pins", int'({sck_o, sdo}), 3);

    // R2: reserved mode, start ignored
    set_ctrl(2'b01, 1'b0, 1'b0, 1'b1);
    send(8'h11, 1'b1);
    idle_ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!sck_o || st_busy) idle_ok = 1'b0;
    end
    chk(idle_ok, "R2 no activity outside mode 10", int'(idle_ok), 1);
    chk(sck_oe == 1'b1, "R10 internal clock drives pin", int'(sck_oe), 1);

    // R4/R10: start, first fall, phase length
    set_ctrl(2'b10, 1'b0, 1'b0, 1'b1);
    while (sck_o) @(negedge clk);
    chk(st_busy && st_shifting, "R4 busy and shifting at first fall",
        int'({st_busy, st_shifting}), 3);
    n = 0;
    while (!sck_o) begin n++; @(negedge clk); end
    chk(n == DIV + 1, "R10 clock phase length", n, DIV + 1);
    set_ctrl(2'b10, 1'b0, 1'b0, 1'b0);
    wait_rx(1);
    @(negedge clk);
    chk(!st_busy && !st_shifting, "R4 busy and shifting fall at byte end",
        int'({st_busy, st_shifting}), 0);
    pulse_rd();

    // R6: back to back, MSB first
    set_ctrl(2'b10, 1'b0, 1'b0, 1'b1);
    send(8'h3C, 1'b1);
    wait_txe();
    chk(st_shifting == 1'b1, "R6 empty returns while shifting", int'(st_shifting), 1);
    send(8'hC3, 1'b1);
    wait_txe();
    set_ctrl(2'b10, 1'b0, 1'b0, 1'b0);
    wait_rx(2);
    pulse_rd();
    wait_rx(3);
    pulse_rd();
    chk(byte_t[2] - byte_t[1] == 16 * (DIV + 1), "R6 no gap between bytes",
        byte_t[2] - byte_t[1], 16 * (DIV + 1));

    // R5: LSB first
    set_ctrl(2'b10, 1'b0, 1'b1, 1'b1);
    send(8'h0B, 1'b1);
    wait_txe();
    set_ctrl(2'b10, 1'b0, 1'b1, 1'b0);
    wait_rx(4);
    chk(rx_data == 8'hF4, "R5 lsb first receive", int'(rx_data), 8'hF4);
    pulse_rd();

    // R8: overrun
    set_ctrl(2'b10, 1'b0, 1'b0, 1'b1);
    send(8'h5A, 1'b1);
    wait_txe();
    send(8'h96, 1'b0);
    wait_txe();
    set_ctrl(2'b10, 1'b0, 1'b0, 1'b0);
    wait_tx(6);
    repeat (3) @(negedge clk);
    chk(st_rx_err == 1'b1, "R8 overrun sets error", int'(st_rx_err), 1);
    chk(rx_data == 8'hA5, "R8 receive register kept", int'(rx_data), 8'hA5);
    pulse_rd();

    // R9: error blocks further receives
    send(8'h77, 1'b0);
    set_ctrl(2'b10, 1'b0, 1'b0, 1'b1);
    wait_txe();
    set_ctrl(2'b10, 1'b0, 1'b0, 1'b0);
    wait_tx(7);
    repeat (3) @(negedge clk);
    chk(st_rx_full == 1'b0, "R9 full stays clear under error", int'(st_rx_full), 0);
    chk(rx_data == 8'hA5, "R9 register unchanged under error", int'(rx_data), 8'hA5);
    chk(st_rx_err == 1'b1, "R9 error sticky", int'(st_rx_err), 1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk(st_rx_err == 1'b0, "R9 clear strobe", int'(st_rx_err), 0);
    send(8'h24, 1'b1);
    set_ctrl(2'b10, 1'b0, 1'b0, 1'b1);
    wait_txe();
    set_ctrl(2'b10, 1'b0, 1'b0, 1'b0);
    wait_rx(6);
    pulse_rd();

    // R11: external clock
    set_ctrl(2'b10, 1'b1, 1'b0, 1'b1);
    chk(sck_oe == 1'b0, "R11 pin not driven", int'(sck_oe), 0);
    send(8'hE1, 1'b1);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      sck_i = 1'b0; repeat (8) @(negedge clk);
      sck_i = 1'b1; repeat (8) @(negedge clk);
    end
    wait_rx(7);
    chk(rx_data == 8'h1E, "R11 external clock receive", int'(rx_data), 8'h1E);
    chk(sck_o == 1'b1, "R11 generated clock idle", int'(sck_o), 1);
    pulse_rd();

    repeat (4) @(negedge clk);
    chk(tx_q.size() == 0 && rx_q.size() == 0, "R7 scoreboard drained",
        tx_q.size() + rx_q.size(), 0);
    finish_run();
  end
endmodule